// File: doc/BRIEF.md
# Synchronous Half-Duplex Byte Shifter

This block is the shift-register mode of a serial controller. It drives a shift clock on one pin and moves one 8-bit byte at a time over a second, bidirectional data pin. A write to the transmit holding register sends a byte. Raising the receiver enable receives a byte. When a transfer ends, a single-cycle interrupt request is raised on the transmit or the receive line. The error line pulses when a received byte overwrites an unread one and the overrun check is on.

A programmable prescaler sets the timing. Each phase of the shift clock lasts `presc + 1` system clock cycles. The clock rests high. Transmit data changes on the falling edge and receive data is sampled on the rising edge. Bits travel least significant bit first. Before the next byte starts, the clock stays high for one extra full shift clock period.

Top module: `sshift_top`

## Requirements
- R1: Out of reset and whenever no transfer is active, `sclk_o` is 1, `data_o` is 1 and `data_oe` is 1. All interrupt outputs, `ren_o` and `oe_flag` are 0.
- R2: A written byte goes out LSB first. Each low and each high phase of `sclk_o` lasts exactly `presc + 1` system clock cycles. `data_o` changes only while `sclk_o` goes low and holds steady at the rising edge.
- R3: After the eighth high phase of a transmitted byte, `tx_irq` pulses for exactly one cycle. With nothing pending, `sclk_o` and `data_o` then stay at 1 and shifting stops.
- R4: A transmit write accepted while a transmission is running is held and sent next. Between the last rising edge of one byte and the first falling edge of the next, `sclk_o` stays high for `3*(presc + 1)` cycles, which is one normal high phase plus one full shift clock period.
- R5: Pulsing `ren_set` while idle starts a reception. `data_oe` is 0 for the whole reception. `data_i` is sampled on each rising edge of `sclk_o`, LSB first.
- R6: After the eighth sample, `rx_data` holds the received byte, `rx_irq` pulses for one cycle and `ren_o` returns to 0 without any software action.
- R7: A `ren_clr` pulse during a reception does not cut the byte short: all eight bits are received, `rx_data` is updated and `rx_irq` still pulses.
- R8: A transmit write during a reception is discarded. It does not disturb the received byte, it starts no transmission afterwards and it never pulses `tx_irq`.
- R9: If a byte completes while the previous byte is unread and `oen` is 1, `oe_flag` becomes 1 and `err_irq` pulses for one cycle. With `oen` at 0, neither happens.
- R10: A `rx_rd` pulse marks the buffer as read, so the next byte raises no overrun. `oe_flag` stays at 1 until `oe_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc | input | PRESC_W | Phase length minus one, in system cycles |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DATA_W | Receive buffer contents |
| ren_set | input | 1 | Sets the receiver enable |
| ren_clr | input | 1 | Clears the receiver enable |
| ren_o | output | 1 | Current receiver enable |
| oen | input | 1 | Overrun check enable |
| oe_clr | input | 1 | Clears the overrun flag |
| oe_flag | output | 1 | Sticky overrun flag |
| sclk_o | output | 1 | Shift clock pin |
| data_o | output | 1 | Data pin output value |
| data_oe | output | 1 | Data pin output enable |
| data_i | input | 1 | Data pin input value |
| tx_irq | output | 1 | Transmit done, one-cycle pulse |
| rx_irq | output | 1 | Receive done, one-cycle pulse |
| err_irq | output | 1 | Overrun error, one-cycle pulse |

## Verification
The embedded properties check on every cycle that the pins rest high while idle and that the data pin is released during reception. They also check that transmit data holds steady across each rising clock edge, that the done pulses last one cycle, that the receiver enable clears itself, that discarded writes leave nothing pending, and that the overrun flag is sticky. Only the bench scenarios can show that whole bytes arrive with the right bit order and that phase and inter-byte gap lengths match the prescaler. The same applies to a cleared enable still finishing its byte, and to overrun depending on the read history across successive bytes.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_GAP  = 2'd3
  } phase_t;

  // system cycles spent in one shift clock phase
  function automatic int unsigned phase_cycles(input int unsigned presc);
    return presc + 1;
  endfunction

  // high time between the last rising edge of a byte and the next fall
  function automatic int unsigned gap_high_cycles(input int unsigned presc);
    return 3 * phase_cycles(presc);
  endfunction

endpackage

// File: rtl/sshift_baud.sv
module sshift_baud #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt_q;

  // counter is held at the reload value while idle so every phase is full length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == '0) begin
      cnt_q <= presc;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);

  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R2

endmodule

// File: rtl/sshift_seq.sv
module sshift_seq
  import sshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_pend,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ren,
  input  logic              data_i,
  output logic              run,
  output logic              rx_active,
  output logic              tx_take,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              data_o,
  output logic              data_oe
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_t             phase_q;
  logic               is_rx_q;
  logic               gap_half_q;
  logic [CNT_W-1:0]   bit_q;
  logic [DATA_W-1:0]  sh_q;
  logic               sclk_q;
  logic               dout_q;

  logic launch;
  logic start_tx;
  logic start_rx;
  logic rise_ev;
  logic fall_ev;
  logic byte_end;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                  input logic bit_in);
    return {bit_in, cur[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] shift_out(input logic [DATA_W-1:0] cur);
    return {1'b0, cur[DATA_W-1:1]};
  endfunction

  assign launch   = (phase_q == PH_IDLE) ||
                    (phase_q == PH_GAP && tick && gap_half_q);
  assign start_tx = launch && tx_pend;
  assign start_rx = launch && !tx_pend && ren;
  assign rise_ev  = (phase_q == PH_LOW) && tick;
  assign byte_end = (phase_q == PH_HIGH) && tick && (bit_q == LAST_BIT);
  assign fall_ev  = (phase_q == PH_HIGH) && tick && (bit_q != LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      is_rx_q    <= 1'b0;
      gap_half_q <= 1'b0;
      bit_q      <= '0;
      sh_q       <= '0;
      sclk_q     <= 1'b1;
      dout_q     <= 1'b1;
    end else begin
      if (start_tx) begin
        phase_q <= PH_LOW;
        is_rx_q <= 1'b0;
        bit_q   <= '0;
        sh_q    <= shift_out(tx_byte);
        dout_q  <= tx_byte[0];
        sclk_q  <= 1'b0;
      end else if (start_rx) begin
        phase_q <= PH_LOW;
        is_rx_q <= 1'b1;
        bit_q   <= '0;
        dout_q  <= 1'b1;
        sclk_q  <= 1'b0;
      end else if (launch) begin
        phase_q <= PH_IDLE;
        is_rx_q <= 1'b0;
        sclk_q  <= 1'b1;
        dout_q  <= 1'b1;
      end else if (rise_ev) begin
        phase_q <= PH_HIGH;
        sclk_q  <= 1'b1;
        if (is_rx_q) begin
          sh_q <= shift_in(sh_q, data_i);
        end
      end else if (fall_ev) begin
        phase_q <= PH_LOW;
        sclk_q  <= 1'b0;
        bit_q   <= bit_q + 1'b1;
        if (!is_rx_q) begin
          dout_q <= sh_q[0];
          sh_q   <= shift_out(sh_q);
        end
      end else if (byte_end) begin
        phase_q    <= PH_GAP;
        gap_half_q <= 1'b0;
        dout_q     <= 1'b1;
      end else if (phase_q == PH_GAP && tick) begin
        gap_half_q <= 1'b1;
      end
    end
  end

  assign run       = (phase_q != PH_IDLE);
  assign rx_active = run && is_rx_q;
  assign tx_take   = start_tx;
  assign tx_done   = byte_end && !is_rx_q;
  assign rx_done   = byte_end && is_rx_q;
  assign rx_byte   = sh_q;
  assign sclk      = sclk_q;
  assign data_o    = dout_q;
  assign data_oe   = !rx_active;

  AST_IDLE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (sclk && data_o && data_oe)); // R1
  AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(data_o)); // R2
  AST_TX_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R3
  AST_RX_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_rx_q) |-> !data_oe); // R5
  AST_GAP_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |-> sclk); // R4

endmodule

// File: rtl/sshift_rxbuf.sv
module sshift_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_rd,
  input  logic              oen,
  input  logic              oe_clr,
  output logic [DATA_W-1:0] rbuf,
  output logic              oe_flag,
  output logic              rir,
  output logic              eir
);

  logic full_q;
  logic oe_q;
  logic [DATA_W-1:0] rbuf_q;
  logic overrun;

  assign overrun = rx_done && full_q && oen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (rx_done) begin
        rbuf_q <= rx_byte;
        full_q <= 1'b1;
      end else if (rx_rd) begin
        full_q <= 1'b0;
      end
      if (overrun) begin
        oe_q <= 1'b1;
      end else if (oe_clr) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign rbuf    = rbuf_q;
  assign oe_flag = oe_q;
  assign rir     = rx_done;
  assign eir     = overrun;

  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_flag && !oe_clr) |=> oe_flag); // R10
  AST_ERR_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eir |=> oe_flag); // R9
  AST_ERR_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    eir |-> rir); // R9

endmodule

// File: rtl/sshift_top.sv
module sshift_top #(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic               tx_wr,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               rx_rd,
  output logic [DATA_W-1:0]  rx_data,
  input  logic               ren_set,
  input  logic               ren_clr,
  output logic               ren_o,
  input  logic               oen,
  input  logic               oe_clr,
  output logic               oe_flag,
  output logic               sclk_o,
  output logic               data_o,
  output logic               data_oe,
  input  logic               data_i,
  output logic               tx_irq,
  output logic               rx_irq,
  output logic               err_irq
);

  logic              tick;
  logic              run;
  logic              rx_active;
  logic              tx_take;
  logic              tx_done;
  logic              rx_done;
  logic [DATA_W-1:0] rx_byte;
  logic              tx_pend_q;
  logic [DATA_W-1:0] tx_hold_q;
  logic              ren_q;
  logic              wr_ok;

  // writes are dropped while a reception (including its gap) owns the pins
  assign wr_ok = tx_wr && !rx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend_q <= 1'b0;
      tx_hold_q <= '0;
    end else begin
      if (wr_ok) begin
        tx_pend_q <= 1'b1;
        tx_hold_q <= tx_data;
      end else if (tx_take) begin
        tx_pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= 1'b0;
    end else if (ren_set) begin
      ren_q <= 1'b1;
    end else if (ren_clr || rx_done) begin
      ren_q <= 1'b0;
    end
  end

  sshift_baud #(.PRESC_W(PRESC_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .presc (presc),
    .tick  (tick)
  );

  sshift_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tx_pend   (tx_pend_q),
    .tx_byte   (tx_hold_q),
    .ren       (ren_q),
    .data_i    (data_i),
    .run       (run),
    .rx_active (rx_active),
    .tx_take   (tx_take),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .sclk      (sclk_o),
    .data_o    (data_o),
    .data_oe   (data_oe)
  );

  sshift_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .rx_rd   (rx_rd),
    .oen     (oen),
    .oe_clr  (oe_clr),
    .rbuf    (rx_data),
    .oe_flag (oe_flag),
    .rir     (rx_irq),
    .eir     (err_irq)
  );

  assign ren_o  = ren_q;
  assign tx_irq = tx_done;

  AST_REN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !ren_set) |=> !ren_o); // R6
  AST_WR_DROPPED_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && tx_wr && !tx_pend_q) |=> !tx_pend_q); // R8
  AST_NO_TX_IRQ_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !tx_irq); // R8

endmodule

// File: tb/sshift_top_bench.sv
module sshift_top_bench;
  import sshift_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc = 8'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       ren_set = 1'b0;
  logic       ren_clr = 1'b0;
  logic       ren_o;
  logic       oen = 1'b0;
  logic       oe_clr = 1'b0;
  logic       oe_flag;
  logic       sclk_o;
  logic       data_o;
  logic       data_oe;
  logic       data_i = 1'b1;
  logic       tx_irq;
  logic       rx_irq;
  logic       err_irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  sshift_top u_sshift_top (
    .clk(clk), .rst_n(rst_n), .presc(presc), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .ren_set(ren_set), .ren_clr(ren_clr),
    .ren_o(ren_o), .oen(oen), .oe_clr(oe_clr), .oe_flag(oe_flag),
    .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  // pin monitor and receive-side slave, sampled midway between edges
  int   lo_cnt = 0, hi_cnt = 0, lo_len = 0, max_hi = 0, min_lo = 0, max_lo = 0;
  int   n_tir = 0, n_rir = 0, n_eir = 0, n_falls = 0, wide_pulse = 0;
  int   rx_idx = 0;
  logic prev_sclk = 1'b1, prev_tir = 1'b0, prev_rir = 1'b0, prev_eir = 1'b0;
  logic [7:0] cap = 8'd0;
  logic [7:0] rx_pat = 8'd0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sclk && !sclk_o) begin
        if (hi_cnt > max_hi) max_hi = hi_cnt;
        lo_cnt = 1;
        n_falls++;
        if (!data_oe) begin
          data_i <= rx_pat[rx_idx[2:0]];
          rx_idx++;
        end
      end else if (!prev_sclk && sclk_o) begin
        lo_len = lo_cnt;
        if (min_lo == 0 || lo_cnt < min_lo) min_lo = lo_cnt;
        if (lo_cnt > max_lo) max_lo = lo_cnt;
        cap = {data_o, cap[7:1]};
        hi_cnt = 1;
      end else if (sclk_o) begin
        hi_cnt++;
      end else begin
        lo_cnt++;
      end
      if (data_oe) rx_idx = 0;
      if (tx_irq) n_tir++;
      if (rx_irq) n_rir++;
      if (err_irq) n_eir++;
      if ((tx_irq && prev_tir) || (rx_irq && prev_rir) || (err_irq && prev_eir))
        wide_pulse++;
      prev_tir = tx_irq;
      prev_rir = rx_irq;
      prev_eir = err_irq;
    end
    prev_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_tx(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_ren;
    @(negedge clk); ren_set = 1'b1;
    @(negedge clk); ren_set = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_oeclr;
    @(negedge clk); oe_clr = 1'b1;
    @(negedge clk); oe_clr = 1'b0;
  endtask

  // which: 0 tx count, 1 rx count, 2 falls count
  task automatic wait_for(input int which, input int target);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      #1;
      if ((which == 0 && n_tir >= target) || (which == 1 && n_rir >= target) ||
          (which == 2 && n_falls >= target)) return;
    end
    chk(1'b0, "timeout", which, target);
  endtask

  task automatic settle(input int p);
    repeat (3 * phase_cycles(p) + 4) @(negedge clk);
  endtask

  task automatic do_rx(input logic [7:0] b, input int p);
    int start;
    start = n_rir;
    rx_pat = b;
    pulse_ren();
    wait_for(1, start + 1);
    settle(p);
  endtask

  task automatic finish_report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_report();
    end
  end

  initial begin
    logic [7:0] b, b2;
    int t0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(sclk_o && data_o && data_oe, "R1 idle pins", {sclk_o, data_o, data_oe}, 7);
    chk(!tx_irq && !rx_irq && !err_irq && !ren_o && !oe_flag, "R1 flags clear",
        {tx_irq, rx_irq, err_irq, ren_o, oe_flag}, 0);

    for (int p = 0; p < 4; p++) begin
      presc = 8'(p);
      // R2/R3: transmit sweep
      for (int k = 0; k < 6; k++) begin
        b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 77 + p * 13 + 5) & 255);
        t0 = n_tir;
        min_lo = 0; max_lo = 0;
        pulse_tx(b);
        wait_for(0, t0 + 1);
        chk(cap == b, "R2 tx byte LSB first", cap, b);
        chk(min_lo == int'(phase_cycles(p)) && max_lo == int'(phase_cycles(p)),
            "R2 low phase length", max_lo, phase_cycles(p));
        settle(p);
        chk(sclk_o && data_o && data_oe && n_tir == t0 + 1, "R3 stop high",
            n_tir - t0, 1);
      end
      // R4: back-to-back transmit with gap
      t0 = n_tir;
      e0 = n_falls;
      pulse_tx(8'h5A);
      wait_for(2, e0 + 1);
      max_hi = 0;
      b2 = 8'(8'hC3 ^ p);
      pulse_tx(b2);
      wait_for(0, t0 + 2);
      chk(cap == b2, "R4 queued byte", cap, b2);
      chk(max_hi == int'(gap_high_cycles(p)), "R4 gap length", max_hi, gap_high_cycles(p));
      settle(p);
      // R5/R6: reception sweep
      for (int k = 0; k < 5; k++) begin
        b = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'((k * 59 + p * 31 + 9) & 255);
        do_rx(b, p);
        chk(rx_data == b, "R5 rx byte", rx_data, b);
        chk(!ren_o, "R6 ren self clear", ren_o, 0);
        pulse_rd();
      end
    end

    presc = 8'd1;
    chk(wide_pulse == 0, "R3 R6 R9 single pulse", wide_pulse, 0);

    // R7: clear enable mid-byte
    t0 = n_rir;
    rx_pat = 8'h6D;
    e0 = n_falls;
    pulse_ren();
    wait_for(2, e0 + 3);
    @(negedge clk); ren_clr = 1'b1;
    @(negedge clk); ren_clr = 1'b0;
    wait_for(1, t0 + 1);
    settle(1);
    chk(rx_data == 8'h6D && n_rir == t0 + 1, "R7 byte finished", rx_data, 8'h6D);
    pulse_rd();

    // R8: transmit write during reception ignored
    t0 = n_tir;
    e0 = n_falls;
    rx_pat = 8'h93;
    pulse_ren();
    wait_for(2, e0 + 2);
    pulse_tx(8'hEE);
    wait_for(1, n_rir + 1);
    settle(1);
    settle(1);
    chk(rx_data == 8'h93, "R8 rx undisturbed", rx_data, 8'h93);
    chk(n_tir == t0 && sclk_o && data_oe && n_falls == e0 + 8, "R8 no tx started",
        n_falls - e0, 8);
    pulse_rd();

    // R9: overrun with check enabled
    oen = 1'b1;
    e0 = n_eir;
    do_rx(8'h11, 1);
    do_rx(8'h22, 1);
    chk(n_eir == e0 + 1 && oe_flag, "R9 overrun flagged", n_eir - e0, 1);
    chk(rx_data == 8'h22, "R9 buffer overwritten", rx_data, 8'h22);
    // R10: sticky flag, then clear; read prevents overrun
    do_rx(8'h33, 1);
    pulse_rd();
    chk(oe_flag, "R10 flag sticky", oe_flag, 1);
    pulse_oeclr();
    @(negedge clk); #1;
    chk(!oe_flag, "R10 flag cleared", oe_flag, 0);
    e0 = n_eir;
    do_rx(8'h44, 1);
    chk(n_eir == e0 && !oe_flag, "R10 read avoids overrun", n_eir - e0, 0);
    // R9: check disabled
    oen = 1'b0;
    do_rx(8'h55, 1);
    chk(n_eir == e0 && !oe_flag, "R9 disabled no error", n_eir - e0, 0);

    done_flag = 1'b1;
    finish_report();
  end

endmodule